// File: doc/BRIEF.md
# Multiplexed Open-Drain GPIO Port

This block is an 8-bit bidirectional I/O port whose pins are shared between general-purpose use and on-chip peripherals (serial channels, timers, external interrupt inputs). Software owns three writable registers: an output latch, an output-type register that picks open-drain or push-pull per pin, and a pull-up enable register. A fourth, read-only register returns the synchronized pin levels. Reading the latch address always returns what was written, never the pin level.

Each pin drives the AND of its latch bit and the peripheral function output routed to it. A peripheral output therefore only reaches the pin while the latch bit holds 1, and a general output is produced by leaving the function output at 1. The block produces per-pin output-enable and drive-value signals for a tri-state pad, resolves the pin level from its own driver, an external driver and the pull-up, and passes that level through a two-flop synchronizer to both the pin-input register and the peripheral inputs. A stop input turns all output enables off.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset the latch reads 0xFF, the output-type register reads 0x00 (all pins open-drain) and the pull-up register reads 0x00.
- R2: A write to address 0 (latch), 1 (output type) or 2 (pull-up) updates that register, which reads back the written value at the same address; a write to address 3 (pin input) changes none of the three registers.
- R3: The effective output of pin i is latch[i] AND funcOut[i]; with output-type bit i equal to 1 (push-pull), padOe[i] is 1 and padDo[i] equals the effective output.
- R4: With output-type bit i equal to 0 (open-drain), padOe[i] is 1 only when the effective output is 0, and padDo[i] is always 0.
- R5: While stopMode is 1, every bit of padOe is 0, regardless of the registers.
- R6: padPullEn equals the pull-up register at all times.
- R7: The level of pin i is the port's own drive when padOe[i] is 1; otherwise it is padExtVal[i] when padExtOe[i] is 1; otherwise 1 if the pull-up is on and 0 if it is off.
- R8: A pin level is seen at address 3 and on funcIn two rising clock edges after it is established; reading address 0 meanwhile still returns the latch contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register address: 0 latch, 1 output type, 2 pull-up, 3 pin input |
| busWe | input | 1 | Write enable, sampled on the rising edge |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr (combinational) |
| funcOut | input | 8 | Peripheral function outputs, one per pin (1 when unused) |
| stopMode | input | 1 | Low-power stop; forces all output enables off |
| padExtOe | input | 8 | External driver active on each pin (0 means floating) |
| padExtVal | input | 8 | Value the external driver puts on each pin |
| padOe | output | 8 | Port output enable per pin |
| padDo | output | 8 | Port drive value per pin |
| padPullEn | output | 8 | Pull-up enable per pin |
| funcIn | output | 8 | Synchronized pin levels to the peripherals |

## Verification
The functions that meet in one cycle are a latch write and the pin synchronizer: the write changes the drive at once while the pin-input register still carries the level from before. The bench provokes this by writing a latch bit that pulls a pulled-up open-drain pin low and then reading address 3 right after the write edge, one edge later and two edges later, expecting the old level twice and the new level once, while address 0 already shows the new latch value. Random mixes of latch, type, pull-up, function output, external drive and stop are judged against bench functions for the drive and the resolved level.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_LATCH = 2'd0,
    ADDR_TYPE  = 2'd1,
    ADDR_PULL  = 2'd2,
    ADDR_PIN   = 2'd3
  } portAddrE;

  typedef struct packed {
    logic            wrLatch;
    logic            wrType;
    logic            wrPull;
    logic [ADDR_W-1:0] rdSel;
  } portStrobeT;
endpackage

// File: rtl/gpio_mux_ctrl.sv
module gpio_mux_ctrl
  import gpio_mux_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output portStrobeT        strobe
);
  portAddrE addrE;

  always_comb begin
    addrE         = portAddrE'(busAddr);
    strobe        = '0;
    strobe.rdSel  = busAddr;
    if (busWe) begin
      unique case (addrE)
        ADDR_LATCH: strobe.wrLatch = 1'b1;
        ADDR_TYPE:  strobe.wrType  = 1'b1;
        ADDR_PULL:  strobe.wrPull  = 1'b1;
        default:    ;
      endcase
    end
  end

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrLatch, strobe.wrType, strobe.wrPull}));

  // R2
  pin_write_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_PIN) |-> !(strobe.wrLatch || strobe.wrType || strobe.wrPull));
endmodule

// File: rtl/gpio_mux_dp.sv
module gpio_mux_dp
  import gpio_mux_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrobeT       strobe,
  input  logic [WIDTH-1:0] busWdata,
  output logic [WIDTH-1:0] busRdata,
  input  logic [WIDTH-1:0] funcOut,
  input  logic             stopMode,
  input  logic [WIDTH-1:0] padExtOe,
  input  logic [WIDTH-1:0] padExtVal,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padDo,
  output logic [WIDTH-1:0] padPullEn,
  output logic [WIDTH-1:0] funcIn
);
  localparam logic [WIDTH-1:0] LATCH_RST = '1;
  localparam logic [WIDTH-1:0] TYPE_RST  = '0;
  localparam logic [WIDTH-1:0] PULL_RST  = '0;

  logic [WIDTH-1:0] latchQ, typeQ, pullQ;
  logic [WIDTH-1:0] effOut, pinLevel;
  logic [WIDTH-1:0] syncA, syncB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchQ <= LATCH_RST;
      typeQ  <= TYPE_RST;
      pullQ  <= PULL_RST;
    end else begin
      if (strobe.wrLatch) latchQ <= busWdata;
      if (strobe.wrType)  typeQ  <= busWdata;
      if (strobe.wrPull)  pullQ  <= busWdata;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    always_comb begin
      effOut[i] = latchQ[i] & funcOut[i];
      padOe[i]  = !stopMode && (typeQ[i] || !effOut[i]);
      padDo[i]  = typeQ[i] & effOut[i];
      if (padOe[i])         pinLevel[i] = padDo[i];
      else if (padExtOe[i]) pinLevel[i] = padExtVal[i];
      else                  pinLevel[i] = pullQ[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinLevel;
      syncB <= syncA;
    end
  end

  assign funcIn    = syncB;
  assign padPullEn = pullQ;

  always_comb begin
    unique case (portAddrE'(strobe.rdSel))
      ADDR_LATCH: busRdata = latchQ;
      ADDR_TYPE:  busRdata = typeQ;
      ADDR_PULL:  busRdata = pullQ;
      default:    busRdata = syncB;
    endcase
  end

  logic [1:0] settleCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                settleCnt <= '0;
    else if (settleCnt != 2'd2) settleCnt <= settleCnt + 2'd1;
  end

  // R5
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopMode |-> (padOe == '0));

  // R4
  od_drive_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((~typeQ) & padDo) == '0);

  // R8
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (settleCnt == 2'd2) |-> (syncB == $past(pinLevel, 2)));

  // R2
  latch_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrLatch |=> (latchQ == $past(busWdata)));

  // R2
  pin_addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrLatch || strobe.wrType || strobe.wrPull)
      |=> ($stable(latchQ) && $stable(typeQ) && $stable(pullQ)));
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [WIDTH-1:0]  busWdata,
  output logic [WIDTH-1:0]  busRdata,
  input  logic [WIDTH-1:0]  funcOut,
  input  logic              stopMode,
  input  logic [WIDTH-1:0]  padExtOe,
  input  logic [WIDTH-1:0]  padExtVal,
  output logic [WIDTH-1:0]  padOe,
  output logic [WIDTH-1:0]  padDo,
  output logic [WIDTH-1:0]  padPullEn,
  output logic [WIDTH-1:0]  funcIn
);
  portStrobeT strobe;

  gpio_mux_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .busAddr(busAddr),
    .busWe  (busWe),
    .strobe (strobe)
  );

  gpio_mux_dp #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .funcOut  (funcOut),
    .stopMode (stopMode),
    .padExtOe (padExtOe),
    .padExtVal(padExtVal),
    .padOe    (padOe),
    .padDo    (padDo),
    .padPullEn(padPullEn),
    .funcIn   (funcIn)
  );
endmodule

// File: tb/gpio_mux_port_test.sv
module gpio_mux_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN;
  logic [1:0]   busAddr;
  logic         busWe;
  logic [W-1:0] busWdata, busRdata, funcOut, padExtOe, padExtVal;
  logic         stopMode;
  logic [W-1:0] padOe, padDo, padPullEn, funcIn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [W-1:0] mLatch, mType, mPull;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_mux_port uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .funcOut(funcOut),
    .stopMode(stopMode), .padExtOe(padExtOe), .padExtVal(padExtVal),
    .padOe(padOe), .padDo(padDo), .padPullEn(padPullEn), .funcIn(funcIn)
  );

  function automatic logic [W-1:0] expOe(input logic [W-1:0] l, t, f, input logic s);
    return s ? '0 : (t | ~(l & f));
  endfunction

  function automatic logic [W-1:0] expDo(input logic [W-1:0] l, t, f);
    return t & l & f;
  endfunction

  function automatic logic [W-1:0] expLevel(input logic [W-1:0] oe, d, eo, ev, p);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++)
      r[i] = oe[i] ? d[i] : (eo[i] ? ev[i] : p[i]);
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [W-1:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic checkPins(input string tag);
    logic [W-1:0] oe, dq, lv, rd;
    oe = expOe(mLatch, mType, funcOut, stopMode);
    dq = expDo(mLatch, mType, funcOut);
    lv = expLevel(oe, dq, padExtOe, padExtVal, mPull);
    check({tag, " R3/R4/R5 padOe"}, padOe, oe);
    check({tag, " R3 R4 padDo"}, padDo, dq);
    check({tag, " R6 padPullEn"}, padPullEn, mPull);
    check({tag, " R7 R8 funcIn"}, funcIn, lv);
    busRead(2'd3, rd);
    check({tag, " R8 pin register"}, rd, lv);
    busRead(2'd0, rd);
    check({tag, " R8 latch read"}, rd, mLatch);
  endtask

  initial begin
    logic [W-1:0] rd;
    void'($urandom(32'h5eed_0042));
    rstN = 1'b0; busAddr = '0; busWe = 1'b0; busWdata = '0;
    funcOut = '1; stopMode = 1'b0; padExtOe = '0; padExtVal = '0;
    mLatch = '1; mType = '0; mPull = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    busRead(2'd0, rd); check("R1 latch reset", rd, 8'hFF);
    busRead(2'd1, rd); check("R1 type reset", rd, 8'h00);
    busRead(2'd2, rd); check("R1 pull reset", rd, 8'h00);
    repeat (2) @(negedge clk);
    checkPins("reset");

    // R2 write/readback and pin-address write ignored
    busWrite(2'd1, 8'hA5); mType = 8'hA5;
    busWrite(2'd2, 8'h3C); mPull = 8'h3C;
    busWrite(2'd3, 8'h00);
    busRead(2'd0, rd); check("R2 latch after pin write", rd, 8'hFF);
    busRead(2'd1, rd); check("R2 type readback", rd, 8'hA5);
    busRead(2'd2, rd); check("R2 pull readback", rd, 8'h3C);

    // R8 latch write meets synchronizer: open-drain pulled-up pin 0
    busWrite(2'd1, 8'h00); mType = 8'h00;
    busWrite(2'd2, 8'hFF); mPull = 8'hFF;
    repeat (2) @(negedge clk);
    busRead(2'd3, rd); check("R8 pin before write", rd, 8'hFF);
    busWrite(2'd0, 8'hFE); mLatch = 8'hFE;
    busRead(2'd3, rd); check("R8 pin old level edge0", rd, 8'hFF);
    busRead(2'd0, rd); check("R8 latch new at once", rd, 8'hFE);
    @(negedge clk);
    busRead(2'd3, rd); check("R8 pin old level edge1", rd, 8'hFF);
    @(negedge clk);
    busRead(2'd3, rd); check("R8 pin new level edge2", rd, 8'hFE);
    checkPins("od low");

    // R7 floating pin without pull-up reads 0, external drive wins when released
    busWrite(2'd0, 8'hFF); mLatch = 8'hFF;
    busWrite(2'd2, 8'h0F); mPull = 8'h0F;
    @(negedge clk);
    padExtOe = 8'h30; padExtVal = 8'h10;
    repeat (2) @(negedge clk);
    checkPins("R7 float");

    // R5 stop with push-pull ones and zeros
    busWrite(2'd1, 8'hFF); mType = 8'hFF;
    busWrite(2'd0, 8'h5A); mLatch = 8'h5A;
    @(negedge clk);
    stopMode = 1'b1;
    repeat (2) @(negedge clk);
    checkPins("R5 stop");
    stopMode = 1'b0;

    // R3 function output gated by latch
    @(negedge clk);
    funcOut = 8'h33;
    repeat (2) @(negedge clk);
    checkPins("R3 func gate");

    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [W-1:0] l, t, p;
      l = W'($urandom); t = W'($urandom); p = W'($urandom);
      busWrite(2'd0, l); mLatch = l;
      busWrite(2'd1, t); mType = t;
      busWrite(2'd2, p); mPull = p;
      if ($urandom_range(3) == 0) busWrite(2'd3, W'($urandom));
      @(negedge clk);
      funcOut   = W'($urandom);
      padExtOe  = W'($urandom);
      padExtVal = W'($urandom);
      stopMode  = ($urandom_range(4) == 0);
      repeat (2) @(negedge clk);
      checkPins("rand");
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule